// File: doc/BRIEF.md
# Comparison and Branch Condition Unit

This block holds the processor's three-state comparison indicator and its overflow toggle. It decides whether a jump is taken. A compare operation presents a register field and a memory field as sign-magnitude values. The block orders the two values and writes LESS, EQUAL or GREATER into the indicator at the next clock edge.

A jump operation presents an opcode class and a 4-bit field code. The block evaluates the selected condition in the same cycle and raises `jump_taken`. When the return address must be written into the jump register, it also raises `save_j`. The block does not update the program counter. It only reports the decision.

The arithmetic unit raises `ovf_set` for one cycle to turn the overflow toggle on. The toggle stays on until reset, or until an overflow jump is taken. That jump turns it off.

Top module: `branch_cond_unit`

## Requirements
- R1: While reset is asserted and after it is released, `cmp_ind` is EQUAL (3'b010), `ovf_flag` is 0, and `jump_taken` and `save_j` are 0 with no operation presented.
- R2: A valid compare (`op_class` = 2'd1) writes the indicator at the next edge as one-hot {GREATER, EQUAL, LESS} on bits 2, 1 and 0. The result is LESS when the register value is below the operand, EQUAL when the two are equal, and GREATER when the register value is above the operand.
- R3: A magnitude of zero is equal to any other zero, whatever the sign. When `sign_in_field` is 0, both compared values are taken as positive.
- R4: In the flag-jump class (`op_class` = 2'd2), codes 0 and 1 are always taken. Code 0 raises `save_j`; code 1 does not.
- R5: Flag-jump code 2 is taken when overflow is on, and the toggle is then off after the edge. Code 3 is taken when overflow is off.
- R6: Flag-jump codes 4, 5 and 6 are taken on LESS, EQUAL and GREATER. Codes 7, 8 and 9 are taken on not-LESS, not-EQUAL and not-GREATER.
- R7: In the register-test class (`op_class` = 2'd3), codes 0 to 5 are taken when the register value is negative, zero, positive, non-negative, nonzero and non-positive. A zero magnitude counts as zero for either sign.
- R8: Register-test codes 6 and 7 are taken when bit 0 of the register magnitude is 0 (even) or 1 (odd).
- R9: `save_j` equals `jump_taken`, except that it is 0 for flag-jump code 1. Flag-jump codes 10 to 15 and register-test codes 8 to 15 are never taken. No jump is taken when `op_valid` is 0 or the class is 0 or 1.
- R10: `ovf_set` turns the toggle on at the next edge. When `ovf_set` and a taken code-2 jump fall in the same cycle, the set wins.
- R11: The indicator keeps its value in every cycle without a valid compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_class | input | 2 | 0 none, 1 compare, 2 flag jump, 3 register test |
| fcode | input | 4 | Field code selecting the jump condition |
| sign_in_field | input | 1 | Compare field includes the sign |
| reg_sign | input | 1 | Register value sign (1 = negative) |
| reg_mag | input | MAG_W | Register value magnitude |
| opd_sign | input | 1 | Memory operand sign (1 = negative) |
| opd_mag | input | MAG_W | Memory operand magnitude |
| ovf_set | input | 1 | One-cycle overflow pulse from arithmetic |
| jump_taken | output | 1 | Jump condition met this cycle |
| save_j | output | 1 | Write return address into J |
| cmp_ind | output | 3 | One-hot comparison indicator {G,E,L} |
| ovf_flag | output | 1 | Overflow toggle |

## Verification
The assertions check several properties on every cycle:
- the indicator stays one-hot;
- the indicator holds between compares;
- `save_j` never rises without `jump_taken`;
- no jump is reported outside the jump classes;
- the overflow pulse sets the toggle;
- a taken code-2 jump clears it.

Only the bench scenarios can show the ordering of signed values, including the plus-zero and minus-zero cases, and the exact condition behind each jump code.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_COMPARE = 2'd1,
    CLS_FLAGJMP = 2'd2,
    CLS_REGTEST = 2'd3
  } op_class_e;

  localparam logic [2:0] IND_LESS    = 3'b001;
  localparam logic [2:0] IND_EQUAL   = 3'b010;
  localparam logic [2:0] IND_GREATER = 3'b100;

  localparam logic [CODE_W-1:0] FJ_ALWAYS_SAVE = 4'd0;
  localparam logic [CODE_W-1:0] FJ_ALWAYS_KEEP = 4'd1;
  localparam logic [CODE_W-1:0] FJ_OVF_ON      = 4'd2;
endpackage

// File: rtl/bcu_reset_sync.sv
module bcu_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcu_signmag_order.sv
module bcu_signmag_order #(
  parameter int MAG_W = 30
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic [2:0]       order
);
  import branch_cond_pkg::*;

  logic a_neg, b_neg;

  always_comb begin
    // a zero magnitude is never negative, so +0 and -0 coincide
    a_neg = a_sign && (a_mag != '0);
    b_neg = b_sign && (b_mag != '0);
    if (a_neg != b_neg)       order = a_neg ? IND_LESS : IND_GREATER;
    else if (a_mag == b_mag)  order = IND_EQUAL;
    else if (a_mag < b_mag)   order = a_neg ? IND_GREATER : IND_LESS;
    else                      order = a_neg ? IND_LESS : IND_GREATER;
  end
endmodule

// File: rtl/bcu_flag_cond.sv
module bcu_flag_cond (
  input  logic [3:0] code,
  input  logic [2:0] ind,
  input  logic       ovf,
  output logic       met
);
  always_comb begin
    unique case (code)
      4'd0, 4'd1: met = 1'b1;
      4'd2:       met = ovf;
      4'd3:       met = !ovf;
      4'd4:       met = ind[0];
      4'd5:       met = ind[1];
      4'd6:       met = ind[2];
      4'd7:       met = !ind[0];
      4'd8:       met = !ind[1];
      4'd9:       met = !ind[2];
      default:    met = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_reg_cond.sv
module bcu_reg_cond #(
  parameter int MAG_W = 30
) (
  input  logic [3:0]       code,
  input  logic             sign,
  input  logic [MAG_W-1:0] mag,
  output logic             met
);
  logic is_zero, is_neg, is_pos;

  always_comb begin
    is_zero = (mag == '0);
    is_neg  = sign && !is_zero;
    is_pos  = !sign && !is_zero;
    unique case (code)
      4'd0:    met = is_neg;
      4'd1:    met = is_zero;
      4'd2:    met = is_pos;
      4'd3:    met = !is_neg;
      4'd4:    met = !is_zero;
      4'd5:    met = !is_pos;
      4'd6:    met = !mag[0];
      4'd7:    met = mag[0];
      default: met = 1'b0;
    endcase
  end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit #(
  parameter int MAG_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_class,
  input  logic [3:0]       fcode,
  input  logic             sign_in_field,
  input  logic             reg_sign,
  input  logic [MAG_W-1:0] reg_mag,
  input  logic             opd_sign,
  input  logic [MAG_W-1:0] opd_mag,
  input  logic             ovf_set,
  output logic             jump_taken,
  output logic             save_j,
  output logic [2:0]       cmp_ind,
  output logic             ovf_flag
);
  import branch_cond_pkg::*;

  logic       rst_sync_n;
  logic [2:0] order, ind_q, ind_d;
  logic       ovf_q, ovf_d;
  logic       ind_en, ovf_en;
  logic       flag_met, reg_met;
  logic       is_flag, is_reg;

  bcu_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bcu_signmag_order #(.MAG_W(MAG_W)) u_order (
    .a_sign(reg_sign && sign_in_field), .a_mag(reg_mag),
    .b_sign(opd_sign && sign_in_field), .b_mag(opd_mag),
    .order(order)
  );

  bcu_flag_cond u_flag (
    .code(fcode), .ind(ind_q), .ovf(ovf_q), .met(flag_met)
  );

  bcu_reg_cond #(.MAG_W(MAG_W)) u_reg (
    .code(fcode), .sign(reg_sign), .mag(reg_mag), .met(reg_met)
  );

  always_comb begin
    is_flag    = op_valid && (op_class == CLS_FLAGJMP);
    is_reg     = op_valid && (op_class == CLS_REGTEST);
    jump_taken = (is_flag && flag_met) || (is_reg && reg_met);
    save_j     = jump_taken && !(is_flag && (fcode == FJ_ALWAYS_KEEP));

    ind_en = op_valid && (op_class == CLS_COMPARE);
    ind_d  = order;

    ovf_en = ovf_set || (is_flag && (fcode == FJ_OVF_ON) && ovf_q);
    ovf_d  = ovf_set;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ind_q <= IND_EQUAL;
      ovf_q <= 1'b0;
    end else begin
      if (ind_en) ind_q <= ind_d;
      if (ovf_en) ovf_q <= ovf_d;
    end
  end

  assign cmp_ind  = ind_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/branch_cond_unit_chk.sv
module branch_cond_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_class,
  input logic [3:0] fcode,
  input logic       ovf_set,
  input logic       jump_taken,
  input logic       save_j,
  input logic [2:0] cmp_ind,
  input logic       ovf_flag
);
  assert_ind_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cmp_ind));

  assert_ind_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_class == 2'd1) |=> $stable(cmp_ind));

  assert_save_needs_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    save_j |-> jump_taken);

  assert_no_jump_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_class[1] == 1'b0) |-> !jump_taken);

  assert_keep_variant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'd2 && fcode == 4'd1) |-> (jump_taken && !save_j));

  assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag);

  assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'd2 && fcode == 4'd2 && jump_taken && !ovf_set)
      |=> !ovf_flag);
endmodule

bind branch_cond_unit branch_cond_unit_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .op_class(op_class),
  .fcode(fcode), .ovf_set(ovf_set), .jump_taken(jump_taken), .save_j(save_j),
  .cmp_ind(cmp_ind), .ovf_flag(ovf_flag)
);

// File: tb/branch_cond_unit_tb_top.sv
module branch_cond_unit_tb_top;
  localparam int MAG_W = 30;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             op_valid;
  logic [1:0]       op_class;
  logic [3:0]       fcode;
  logic             sign_in_field;
  logic             reg_sign;
  logic [MAG_W-1:0] reg_mag;
  logic             opd_sign;
  logic [MAG_W-1:0] opd_mag;
  logic             ovf_set;
  logic             jump_taken, save_j, ovf_flag;
  logic [2:0]       cmp_ind;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_cond_unit #(.MAG_W(MAG_W)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 0; op_class = 0; fcode = 0; sign_in_field = 1;
    reg_sign = 0; reg_mag = 0; opd_sign = 0; opd_mag = 0; ovf_set = 0;
  endtask

  function automatic longint sval(bit s, longint m);
    return s ? -m : m;
  endfunction

  function automatic int ref_order(bit rs, longint rm, bit os, longint om, bit sif);
    longint a = sval(rs && sif, rm);
    longint b = sval(os && sif, om);
    if (a < b) return 1;
    if (a == b) return 2;
    return 4;
  endfunction

  task automatic do_cmp(string req, bit rs, longint rm, bit os, longint om, bit sif);
    @(negedge clk);
    op_valid = 1; op_class = 2'd1; sign_in_field = sif;
    reg_sign = rs; reg_mag = rm[MAG_W-1:0]; opd_sign = os; opd_mag = om[MAG_W-1:0];
    @(negedge clk);
    idle();
    #1 chk(req, cmp_ind, ref_order(rs, rm, os, om, sif));
  endtask

  task automatic do_jump(bit [1:0] cls, bit [3:0] code, bit rs, longint rm,
                         output bit taken, output bit sj);
    @(negedge clk);
    op_valid = 1; op_class = cls; fcode = code; reg_sign = rs; reg_mag = rm[MAG_W-1:0];
    #1 taken = jump_taken; sj = save_j;
  endtask

  task automatic pulse_ovf();
    @(negedge clk); ovf_set = 1;
    @(negedge clk); ovf_set = 0;
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 ind in reset", cmp_ind, 2);
    chk("R1 ovf in reset", ovf_flag, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 ind after reset", cmp_ind, 2);
    chk("R1 ovf after reset", ovf_flag, 0);
    chk("R1 no jump idle", jump_taken, 0);
  endtask

  task automatic t_compare();
    do_cmp("R2 pos less", 0, 5, 0, 9, 1);
    do_cmp("R2 pos greater", 0, 9, 0, 5, 1);
    do_cmp("R2 equal", 0, 77, 0, 77, 1);
    do_cmp("R2 neg vs pos", 1, 3, 0, 2, 1);
    do_cmp("R2 both neg", 1, 3, 1, 8, 1);
    do_cmp("R3 plus zero minus zero", 0, 0, 1, 0, 1);
    do_cmp("R3 minus zero vs plus zero", 1, 0, 0, 0, 1);
    do_cmp("R3 signless field", 1, 8, 0, 3, 0);
    do_cmp("R2 max magnitude", 0, (1 << MAG_W) - 1, 0, (1 << MAG_W) - 2, 1);
    // R11: the indicator holds through idle cycles and jumps
    repeat (3) @(negedge clk);
    chk("R11 hold idle", cmp_ind, 4);
  endtask

  task automatic t_flag_jumps();
    bit tk, sj;
    int ind_sel[3] = '{1, 2, 4};
    for (int k = 0; k < 3; k++) begin
      int ind = ind_sel[k];
      if (ind == 1) do_cmp("R2 set less", 0, 1, 0, 2, 1);
      if (ind == 2) do_cmp("R2 set equal", 0, 2, 0, 2, 1);
      if (ind == 4) do_cmp("R2 set greater", 0, 3, 0, 2, 1);
      for (int c = 0; c < 16; c++) begin
        bit e;
        case (c)
          0, 1: e = 1;
          3: e = 1;
          2: e = 0;
          4: e = (ind == 1);
          5: e = (ind == 2);
          6: e = (ind == 4);
          7: e = (ind != 1);
          8: e = (ind != 2);
          9: e = (ind != 4);
          default: e = 0;
        endcase
        do_jump(2'd2, c[3:0], 0, 0, tk, sj);
        chk($sformatf("R6 flag code %0d ind %0d", c, ind), tk, e);
        chk($sformatf("R9 save code %0d", c), sj, (c == 1) ? 0 : e);
      end
      idle();
      @(negedge clk);
      chk("R11 hold across jumps", cmp_ind, ind);
    end
  endtask

  task automatic t_reg_tests();
    bit tk, sj;
    longint mags[4] = '{0, 0, 6, 7};
    bit     sgns[4] = '{0, 1, 1, 0};
    for (int v = 0; v < 4; v++) begin
      longint val = sval(sgns[v], mags[v]);
      for (int c = 0; c < 16; c++) begin
        bit e;
        case (c)
          0: e = val < 0;
          1: e = val == 0;
          2: e = val > 0;
          3: e = val >= 0;
          4: e = val != 0;
          5: e = val <= 0;
          6: e = (mags[v] % 2) == 0;
          7: e = (mags[v] % 2) == 1;
          default: e = 0;
        endcase
        do_jump(2'd3, c[3:0], sgns[v], mags[v], tk, sj);
        chk($sformatf("%s reg code %0d val %0d", (c >= 6) ? "R8" : "R7", c, val), tk, e);
        chk($sformatf("R9 reg save code %0d", c), sj, e);
      end
    end
    // R9: an invalid op or a compare class never jumps
    @(negedge clk);
    op_valid = 0; op_class = 2'd2; fcode = 0;
    #1 chk("R9 invalid op", jump_taken, 0);
    op_valid = 1; op_class = 2'd1;
    #1 chk("R9 compare class no jump", jump_taken, 0);
    idle();
  endtask

  task automatic t_overflow();
    bit tk, sj;
    idle();
    do_jump(2'd2, 4'd2, 0, 0, tk, sj);
    chk("R5 code2 off not taken", tk, 0);
    do_jump(2'd2, 4'd3, 0, 0, tk, sj);
    chk("R5 code3 off taken", tk, 1);
    idle();
    pulse_ovf();
    chk("R10 set by pulse", ovf_flag, 1);
    repeat (3) @(negedge clk);
    chk("R10 stays on", ovf_flag, 1);
    do_jump(2'd2, 4'd3, 0, 0, tk, sj);
    chk("R5 code3 on not taken", tk, 0);
    do_jump(2'd2, 4'd2, 0, 0, tk, sj);
    chk("R5 code2 on taken", tk, 1);
    chk("R5 code2 saves", sj, 1);
    @(negedge clk); idle();
    #1 chk("R5 cleared after code2", ovf_flag, 0);
    pulse_ovf();
    do_jump(2'd2, 4'd2, 0, 0, tk, sj);
    ovf_set = 1;
    @(negedge clk); idle();
    #1 chk("R10 set wins over clear", ovf_flag, 1);
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset clears ovf", ovf_flag, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_compare();
    t_flag_jumps();
    t_reg_tests();
    t_overflow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule